// File: doc/BRIEF.md
# Command and Mode Write-Combining Register Adapter

This block sits between a host that programs a storage-card host controller through the usual register view, with byte, halfword and word accesses, and a controller core whose register file accepts only aligned 32-bit accesses. On that core the transfer-mode halfword and the command halfword share one 32-bit word. Writing the command starts a transaction, so it must never go out before the mode bits that belong with it.

In the combined variant (`MIXED_CTRL = 0`) the adapter keeps a private 32-bit shadow of that word. A mode write lands only in the shadow. The later command write fills the upper half and sends the whole word downstream as one write. In the mixed-control variant (`MIXED_CTRL = 1`) the mode bits live in a separate mixed-control register at offset 0x48 and are updated there by read-modify-write. In both variants the adapter turns every other narrow write into a read-modify-write of the aligned word. It also makes up the values of a few registers the core lacks: a one-bit slot interrupt summary, a fixed power-control byte and, in the mixed variant, the version halfword.

The host side is a valid/ready request port with a one-cycle response strobe. Only one access is in flight at a time. The downstream side is a word-wide valid/ready port; its read data is taken in the cycle the request is accepted.

Top module: `cmdmode_shim`

## Requirements
- R1: In the combined variant a halfword (size 1) write to offset 0x0C updates only the low half of the shadow word, produces no downstream access, and its response follows acceptance on the next cycle.
- R2: In the combined variant a halfword write to offset 0x0E replaces the upper half of the shadow word and then issues exactly one downstream 32-bit write of the full shadow word to offset 0x0C. In the mixed variant the same write is an ordinary halfword read-modify-write.
- R3: In the combined variant halfword reads of 0x0C and 0x0E return the low and high halves of the shadow word, not the core's register.
- R4: In the mixed variant a halfword write to 0x0C reads the word at 0x48, clears bits 5:0, ORs in the written value ANDed with 0x37, and writes the result back to 0x48.
- R5: In the mixed variant a halfword read of 0x0C returns the word at 0x48 ANDed with 0x37, and a halfword read of 0xFE returns 0x0002.
- R6: Any other byte (size 0) or halfword write reads the aligned word and replaces the byte or halfword that starts at bit 8*(offset mod 4), leaving the other bits unchanged, then writes the word back. Word writes (size 2) pass straight through.
- R7: Any other read returns the addressed byte or halfword of the aligned word, shifted down to bit 0. Word reads return the whole word. Every downstream address is word aligned.
- R8: A halfword read of 0xFC returns 1 when the word at 0x30 ANDed with the word at 0x38 is nonzero, and 0 otherwise.
- R9: A byte read of 0x29 returns 0x0D with no downstream access. A byte write to 0x29 is discarded with no downstream access.
- R10: The host port accepts no new request from acceptance until one cycle after the single-cycle response. A downstream request that is not yet accepted holds its address, direction and data.
- R11: After reset the host port is ready, no response or downstream request is pending, and the shadow word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Host request valid |
| upReady | output | 1 | Host request accepted when high with upValid |
| upWrite | input | 1 | 1 = write, 0 = read |
| upAddr | input | ADDR_W | Byte offset in the host register view |
| upSize | input | 2 | 0 byte, 1 halfword, 2 word |
| upWdata | input | 32 | Write data, right-justified |
| rspValid | output | 1 | One-cycle completion strobe |
| rspData | output | 32 | Read result, right-justified |
| dnValid | output | 1 | Downstream word request valid |
| dnReady | input | 1 | Downstream request accepted |
| dnWrite | output | 1 | Downstream direction |
| dnAddr | output | ADDR_W | Downstream word-aligned address |
| dnWdata | output | 32 | Downstream write data |
| dnRdata | input | 32 | Downstream read data, valid while dnValid and dnReady |

## Verification
A corrupted shadow word would not show up on a mode write, because that write is silent downstream. It shows up later, either on the fused word that the next command write issues or on the next shadow read-back, which can be many accesses later. The bench therefore reads back after every shadow update and checks the downstream word that a write produces. A wrong lane or mask in a read-modify-write corrupts neighbouring bytes, and this is visible in the downstream word on the same access. A wedged control state shows up at once as a host port that never becomes ready again.

// File: rtl/cmdmode_pkg.sv
package cmdmode_pkg;

  localparam int DATA_W = 32;

  // Host-view offsets whose handling differs from a plain word access
  localparam logic [7:0] MODE_OFF    = 8'h0C;
  localparam logic [7:0] CMD_OFF     = 8'h0E;
  localparam logic [7:0] PWR_OFF     = 8'h29;
  localparam logic [7:0] INTSTAT_OFF = 8'h30;
  localparam logic [7:0] SIGEN_OFF   = 8'h38;
  localparam logic [7:0] MIXCTL_OFF  = 8'h48;
  localparam logic [7:0] SLOT_OFF    = 8'hFC;
  localparam logic [7:0] VER_OFF     = 8'hFE;

  localparam logic [DATA_W-1:0] MIX_KEEP  = 32'h0000_0037;
  localparam logic [DATA_W-1:0] MIX_CLEAR = 32'h0000_003F;
  localparam logic [DATA_W-1:0] PWR_VALUE = 32'h0000_000D;
  localparam logic [DATA_W-1:0] VER_VALUE = 32'h0000_0002;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [3:0] {
    OP_PASS_RD, OP_PASS_WR, OP_RMW, OP_CACHE_LO, OP_CACHE_HI, OP_CACHE_RD,
    OP_CONST_RD, OP_DROP, OP_MIX_WR, OP_MIX_RD, OP_SLOT_RD
  } op_e;

  typedef enum logic [2:0] {ADR_ALIGNED, ADR_MIX, ADR_INTSTAT, ADR_SIGEN, ADR_MODE} adr_sel_e;
  typedef enum logic [1:0] {WR_RAW, WR_MERGE, WR_MIX, WR_FUSED} wr_sel_e;
  typedef enum logic [2:0] {RES_LANE, RES_MIX, RES_SLOT, RES_CACHE, RES_CONST} res_sel_e;

  typedef struct packed {
    logic     capture;
    logic     loadWord;
    logic     loadAux;
    logic     cacheLoWe;
    logic     cacheHiWe;
    adr_sel_e adrSel;
    wr_sel_e  wrSel;
    res_sel_e resSel;
  } strobe_t;

endpackage

// File: rtl/cmdmode_ctrl.sv
module cmdmode_ctrl
  import cmdmode_pkg::*;
#(
  parameter bit MIXED_CTRL = 1'b0,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  input  logic              upWrite,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic              dnReady,
  output logic              upReady,
  output logic              rspValid,
  output logic              dnValid,
  output logic              dnWrite,
  output strobe_t           strb
);

  typedef enum logic [2:0] {S_IDLE, S_RD_A, S_RD_B, S_WR, S_RSP} state_e;

  state_e state, stateNext;
  op_e    opQ, opNext;

  function automatic logic isAt(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Classify the incoming access
  always_comb begin
    opNext = upWrite ? OP_RMW : OP_PASS_RD;
    if (upWrite) begin
      if (upSize == SZ_HALF && isAt(upAddr, MODE_OFF))
        opNext = MIXED_CTRL ? OP_MIX_WR : OP_CACHE_LO;
      else if (upSize == SZ_HALF && isAt(upAddr, CMD_OFF) && !MIXED_CTRL)
        opNext = OP_CACHE_HI;
      else if (upSize == SZ_BYTE && isAt(upAddr, PWR_OFF))
        opNext = OP_DROP;
      else if (upSize != SZ_BYTE && upSize != SZ_HALF)
        opNext = OP_PASS_WR;
    end else begin
      if (upSize == SZ_HALF && isAt(upAddr, MODE_OFF))
        opNext = MIXED_CTRL ? OP_MIX_RD : OP_CACHE_RD;
      else if (upSize == SZ_HALF && isAt(upAddr, CMD_OFF) && !MIXED_CTRL)
        opNext = OP_CACHE_RD;
      else if (upSize == SZ_HALF && isAt(upAddr, SLOT_OFF))
        opNext = OP_SLOT_RD;
      else if (upSize == SZ_HALF && isAt(upAddr, VER_OFF) && MIXED_CTRL)
        opNext = OP_CONST_RD;
      else if (upSize == SZ_BYTE && isAt(upAddr, PWR_OFF))
        opNext = OP_CONST_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_PASS_RD;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && upValid) opQ <= opNext;
    end
  end

  always_comb begin
    stateNext = state;
    upReady   = 1'b0;
    rspValid  = 1'b0;
    dnValid   = 1'b0;
    dnWrite   = 1'b0;
    strb      = '0;

    unique case (opQ)
      OP_MIX_RD:   strb.resSel = RES_MIX;
      OP_SLOT_RD:  strb.resSel = RES_SLOT;
      OP_CACHE_RD: strb.resSel = RES_CACHE;
      OP_CONST_RD: strb.resSel = RES_CONST;
      default:     strb.resSel = RES_LANE;
    endcase

    unique case (state)
      S_IDLE: begin
        upReady = 1'b1;
        if (upValid) begin
          strb.capture   = 1'b1;
          strb.cacheLoWe = (opNext == OP_CACHE_LO);
          strb.cacheHiWe = (opNext == OP_CACHE_HI);
          unique case (opNext)
            OP_PASS_RD, OP_RMW, OP_MIX_WR, OP_MIX_RD, OP_SLOT_RD: stateNext = S_RD_A;
            OP_PASS_WR, OP_CACHE_HI:                              stateNext = S_WR;
            default:                                              stateNext = S_RSP;
          endcase
        end
      end
      S_RD_A: begin
        dnValid = 1'b1;
        if (opQ == OP_MIX_WR || opQ == OP_MIX_RD) strb.adrSel = ADR_MIX;
        else if (opQ == OP_SLOT_RD)               strb.adrSel = ADR_INTSTAT;
        else                                      strb.adrSel = ADR_ALIGNED;
        if (dnReady) begin
          strb.loadWord = 1'b1;
          if (opQ == OP_SLOT_RD)                     stateNext = S_RD_B;
          else if (opQ == OP_RMW || opQ == OP_MIX_WR) stateNext = S_WR;
          else                                        stateNext = S_RSP;
        end
      end
      S_RD_B: begin
        dnValid     = 1'b1;
        strb.adrSel = ADR_SIGEN;
        if (dnReady) begin
          strb.loadAux = 1'b1;
          stateNext    = S_RSP;
        end
      end
      S_WR: begin
        dnValid = 1'b1;
        dnWrite = 1'b1;
        if (opQ == OP_CACHE_HI) begin
          strb.adrSel = ADR_MODE;
          strb.wrSel  = WR_FUSED;
        end else if (opQ == OP_MIX_WR) begin
          strb.adrSel = ADR_MIX;
          strb.wrSel  = WR_MIX;
        end else begin
          strb.adrSel = ADR_ALIGNED;
          strb.wrSel  = (opQ == OP_RMW) ? WR_MERGE : WR_RAW;
        end
        if (dnReady) stateNext = S_RSP;
      end
      S_RSP: begin
        rspValid  = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/cmdmode_dpath.sv
module cmdmode_dpath
  import cmdmode_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [DATA_W-1:0] dnRdata,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W-1:0] rspData
);

  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam int SH_W   = LANE_W + 3;
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic [DATA_W-1:0] reqWdata, wordQ, auxQ, cacheQ;
  logic [DATA_W-1:0] sizeMask, merged, laneData;
  logic [SH_W-1:0]   shift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqSize  <= '0;
      reqWdata <= '0;
      wordQ    <= '0;
      auxQ     <= '0;
      cacheQ   <= '0;
    end else begin
      if (strb.capture) begin
        reqAddr  <= upAddr;
        reqSize  <= upSize;
        reqWdata <= upWdata;
      end
      if (strb.cacheLoWe) cacheQ[HALF_W-1:0]      <= upWdata[HALF_W-1:0];
      if (strb.cacheHiWe) cacheQ[DATA_W-1:HALF_W] <= upWdata[HALF_W-1:0];
      if (strb.loadWord)  wordQ <= dnRdata;
      if (strb.loadAux)   auxQ  <= dnRdata;
    end
  end

  always_comb begin
    unique case (reqSize)
      SZ_BYTE: sizeMask = DATA_W'(8'hFF);
      SZ_HALF: sizeMask = DATA_W'({HALF_W{1'b1}});
      default: sizeMask = '1;
    endcase
    shift    = (reqSize == SZ_BYTE || reqSize == SZ_HALF) ? {reqAddr[LANE_W-1:0], 3'b000} : '0;
    merged   = (wordQ & ~(sizeMask << shift)) | ((reqWdata & sizeMask) << shift);
    laneData = (wordQ >> shift) & sizeMask;
  end

  always_comb begin
    unique case (strb.adrSel)
      ADR_MIX:     dnAddr = ADDR_W'(MIXCTL_OFF);
      ADR_INTSTAT: dnAddr = ADDR_W'(INTSTAT_OFF);
      ADR_SIGEN:   dnAddr = ADDR_W'(SIGEN_OFF);
      ADR_MODE:    dnAddr = ADDR_W'(MODE_OFF);
      default:     dnAddr = {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    endcase

    unique case (strb.wrSel)
      WR_MERGE: dnWdata = merged;
      WR_MIX:   dnWdata = (wordQ & ~MIX_CLEAR) | (reqWdata & MIX_KEEP);
      WR_FUSED: dnWdata = cacheQ;
      default:  dnWdata = reqWdata;
    endcase

    unique case (strb.resSel)
      RES_MIX:   rspData = wordQ & MIX_KEEP;
      RES_SLOT:  rspData = DATA_W'(|(wordQ & auxQ));
      RES_CACHE: rspData = reqAddr[1] ? DATA_W'(cacheQ[DATA_W-1:HALF_W])
                                      : DATA_W'(cacheQ[HALF_W-1:0]);
      RES_CONST: rspData = (reqAddr == ADDR_W'(VER_OFF)) ? VER_VALUE : PWR_VALUE;
      default:   rspData = laneData;
    endcase
  end

endmodule

// File: rtl/cmdmode_shim.sv
module cmdmode_shim
  import cmdmode_pkg::*;
#(
  parameter bit MIXED_CTRL = 1'b0,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  output logic              upReady,
  input  logic              upWrite,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic [DATA_W-1:0] upWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              dnValid,
  input  logic              dnReady,
  output logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnWdata,
  input  logic [DATA_W-1:0] dnRdata
);

  strobe_t strb;

  cmdmode_ctrl #(.MIXED_CTRL(MIXED_CTRL), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .upValid(upValid), .upWrite(upWrite),
    .upAddr(upAddr), .upSize(upSize), .dnReady(dnReady),
    .upReady(upReady), .rspValid(rspValid), .dnValid(dnValid),
    .dnWrite(dnWrite), .strb(strb)
  );

  cmdmode_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .upAddr(upAddr), .upSize(upSize),
    .upWdata(upWdata), .dnRdata(dnRdata), .dnAddr(dnAddr),
    .dnWdata(dnWdata), .rspData(rspData)
  );

endmodule

// File: rtl/cmdmode_shim_chk.sv
module cmdmode_shim_chk
  import cmdmode_pkg::*;
#(
  parameter bit MIXED_CTRL = 1'b0,
  parameter int ADDR_W     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              upValid,
  input logic              upReady,
  input logic              upWrite,
  input logic [ADDR_W-1:0] upAddr,
  input logic [1:0]        upSize,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              dnValid,
  input logic              dnReady,
  input logic              dnWrite,
  input logic [ADDR_W-1:0] dnAddr,
  input logic [DATA_W-1:0] dnWdata
);

  logic accept;
  assign accept = upValid && upReady;

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !upReady);

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> upReady && !rspValid);

  assert_dn_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnReady |=> dnValid && $stable(dnAddr) && $stable(dnWrite) && $stable(dnWdata));

  assert_dn_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> dnAddr[1:0] == 2'b00);

  assert_mode_cached_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!MIXED_CTRL && accept && upWrite && upSize == SZ_HALF && upAddr == ADDR_W'(MODE_OFF))
      |=> rspValid && !dnValid);

  assert_pwr_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && upWrite && upSize == SZ_BYTE && upAddr == ADDR_W'(PWR_OFF))
      |=> rspValid && !dnValid);

  assert_pwr_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !upWrite && upSize == SZ_BYTE && upAddr == ADDR_W'(PWR_OFF))
      |=> rspValid && rspData == PWR_VALUE);

endmodule

bind cmdmode_shim cmdmode_shim_chk #(.MIXED_CTRL(MIXED_CTRL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .upValid(upValid), .upReady(upReady), .upWrite(upWrite),
  .upAddr(upAddr), .upSize(upSize), .rspValid(rspValid), .rspData(rspData),
  .dnValid(dnValid), .dnReady(dnReady), .dnWrite(dnWrite), .dnAddr(dnAddr),
  .dnWdata(dnWdata)
);

// File: tb/test_cmdmode_shim.sv
`timescale 1ns/1ps
module test_cmdmode_shim;

  typedef struct {
    string       rid;
    bit          chk;
    logic [31:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        upValid [2], upWrite [2], upReady [2], rspValid [2];
  logic        dnValid [2], dnReady [2], dnWrite [2];
  logic [7:0]  upAddr [2], dnAddr [2];
  logic [1:0]  upSize [2];
  logic [31:0] upWdata [2], rspData [2], dnWdata [2], dnRdata [2];

  logic [31:0] mem [2][64];
  logic        bdWe [2];
  logic [5:0]  bdAddr [2];
  logic [31:0] bdData [2];
  int          wrCnt [2];

  exp_t q0[$], q1[$];
  int tbChecks = 0, tbFails = 0, monChecks = 0, monFails = 0, wdFail = 0;
  logic [7:0] lf = 8'h5A;

  cmdmode_shim #(.MIXED_CTRL(1'b0), .ADDR_W(8)) i_cmdmode_shim (
    .clk(clk), .rstN(rstN), .upValid(upValid[0]), .upReady(upReady[0]),
    .upWrite(upWrite[0]), .upAddr(upAddr[0]), .upSize(upSize[0]), .upWdata(upWdata[0]),
    .rspValid(rspValid[0]), .rspData(rspData[0]), .dnValid(dnValid[0]), .dnReady(dnReady[0]),
    .dnWrite(dnWrite[0]), .dnAddr(dnAddr[0]), .dnWdata(dnWdata[0]), .dnRdata(dnRdata[0])
  );

  cmdmode_shim #(.MIXED_CTRL(1'b1), .ADDR_W(8)) i_cmdmode_shim_mix (
    .clk(clk), .rstN(rstN), .upValid(upValid[1]), .upReady(upReady[1]),
    .upWrite(upWrite[1]), .upAddr(upAddr[1]), .upSize(upSize[1]), .upWdata(upWdata[1]),
    .rspValid(rspValid[1]), .rspData(rspData[1]), .dnValid(dnValid[1]), .dnReady(dnReady[1]),
    .dnWrite(dnWrite[1]), .dnAddr(dnAddr[1]), .dnWdata(dnWdata[1]), .dnRdata(dnRdata[1])
  );

  assign dnRdata[0] = mem[0][dnAddr[0][7:2]];
  assign dnRdata[1] = mem[1][dnAddr[1][7:2]];

  // Downstream register model, one per unit
  always @(posedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (!rstN) begin
        for (int w = 0; w < 64; w++) mem[u][w] <= 32'h0;
        wrCnt[u] <= 0;
      end else if (bdWe[u]) begin
        mem[u][bdAddr[u]] <= bdData[u];
      end else if (dnValid[u] && dnReady[u] && dnWrite[u]) begin
        mem[u][dnAddr[u][7:2]] <= dnWdata[u];
        wrCnt[u] <= wrCnt[u] + 1;
      end
    end
  end

  // Downstream back-pressure pattern
  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    dnReady[0] <= lf[0] | lf[2];
    dnReady[1] <= lf[1] | lf[3];
  end

  // Monitor: pop expected responses and compare
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (rstN && rspValid[u]) begin
        exp_t e;
        if ((u == 0 ? q0.size() : q1.size()) == 0) begin
          monFails++;
          $display("FAIL unit%0d unexpected response data=%h expected none", u, rspData[u]);
        end else begin
          e = (u == 0) ? q0.pop_front() : q1.pop_front();
          if (e.chk) begin
            monChecks++;
            if (rspData[u] !== e.data) begin
              monFails++;
              $display("FAIL %s unit%0d read data actual=%h expected=%h", e.rid, u, rspData[u], e.data);
            end
          end
        end
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", tbChecks + monChecks,
             tbFails + monFails + wdFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    wdFail = 1;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  task automatic check(string rid, logic [31:0] act, logic [31:0] expv);
    tbChecks++;
    if (act !== expv) begin
      tbFails++;
      $display("FAIL %s actual=%h expected=%h", rid, act, expv);
    end
  endtask

  function automatic int qsz(int u);
    return (u == 0) ? q0.size() : q1.size();
  endfunction

  task automatic access(int u, bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] wd,
                        string rid, logic [31:0] expd);
    exp_t e;
    e.rid = rid; e.chk = !wr; e.data = expd;
    @(negedge clk);
    if (u == 0) q0.push_back(e); else q1.push_back(e);
    upWrite[u] = wr; upAddr[u] = a; upSize[u] = sz; upWdata[u] = wd; upValid[u] = 1'b1;
    while (!upReady[u]) @(negedge clk);
    @(negedge clk);
    upValid[u] = 1'b0;
    check("R10 busy after accept", {31'b0, upReady[u]}, 32'h0);
    while (qsz(u) != 0) @(negedge clk);
  endtask

  task automatic poke(int u, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bdWe[u] = 1'b1; bdAddr[u] = a[7:2]; bdData[u] = d;
    @(negedge clk);
    bdWe[u] = 1'b0;
  endtask

  initial begin
    int c;
    for (int u = 0; u < 2; u++) begin
      upValid[u] = 1'b0; upWrite[u] = 1'b0; upAddr[u] = '0; upSize[u] = '0;
      upWdata[u] = '0; bdWe[u] = 1'b0; bdAddr[u] = '0; bdData[u] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check("R11 ready", {31'b0, upReady[u]}, 32'h1);
      check("R11 no rsp", {31'b0, rspValid[u]}, 32'h0);
      check("R11 no dn", {31'b0, dnValid[u]}, 32'h0);
    end

    for (int u = 0; u < 2; u++) begin
      poke(u, 8'h28, 32'hA1B2C3D4);
      poke(u, 8'h10, 32'h11223344);
      poke(u, 8'h30, 32'h00000050);
      poke(u, 8'h38, 32'h00000040);
      poke(u, 8'hFC, 32'hBEEF0000);
    end
    poke(1, 8'h48, 32'h12345678);

    // R11 / R3: shadow starts at zero
    access(0, 0, 8'h0C, 2'd1, 0, "R11", 32'h0);

    // R1 / R3: mode write is cached only
    c = wrCnt[0];
    access(0, 1, 8'h0C, 2'd1, 32'h0023, "R1", 0);
    check("R1 no downstream write", wrCnt[0], c);
    check("R1 register untouched", mem[0][3], 32'h0);
    access(0, 0, 8'h0C, 2'd1, 0, "R3", 32'h0023);

    // R2: command write fuses with the mode
    access(0, 1, 8'h0E, 2'd1, 32'h1A3B, "R2", 0);
    check("R2 one write", wrCnt[0], c + 1);
    check("R2 fused word", mem[0][3], 32'h1A3B0023);
    access(0, 0, 8'h0E, 2'd1, 0, "R3", 32'h1A3B);
    access(0, 1, 8'h0C, 2'd1, 32'h0011, "R1", 0);
    access(0, 1, 8'h0E, 2'd1, 32'h0C52, "R2", 0);
    check("R2 second fused word", mem[0][3], 32'h0C520011);

    // R4 / R5: mixed-control variant
    access(1, 1, 8'h0C, 2'd1, 32'h00FF, "R4", 0);
    check("R4 mixctl rmw", mem[1][18], 32'h12345677);
    access(1, 0, 8'h0C, 2'd1, 0, "R5", 32'h37);
    access(1, 1, 8'h0C, 2'd1, 32'h0012, "R4", 0);
    check("R4 mixctl rmw 2", mem[1][18], 32'h12345652);
    access(1, 0, 8'h0C, 2'd1, 0, "R5", 32'h12);
    access(1, 0, 8'hFE, 2'd1, 0, "R5 version", 32'h0002);
    access(1, 1, 8'h0E, 2'd1, 32'h1A3B, "R2 mixed", 0);
    check("R2 mixed command rmw", mem[1][3], 32'h1A3B0000);

    // R6: narrow writes merge into the aligned word
    access(0, 1, 8'h12, 2'd0, 32'hAA, "R6", 0);
    check("R6 byte lane2", mem[0][4], 32'h11AA3344);
    access(0, 1, 8'h10, 2'd1, 32'h5566, "R6", 0);
    check("R6 half lane0", mem[0][4], 32'h11AA5566);
    access(1, 1, 8'h13, 2'd0, 32'h77, "R6", 0);
    check("R6 byte lane3", mem[1][4], 32'h77223344);
    access(0, 1, 8'h40, 2'd2, 32'hDEADBEEF, "R6", 0);
    check("R6 word pass", mem[0][16], 32'hDEADBEEF);

    // R7: narrow reads extract the lane
    access(0, 0, 8'h2A, 2'd0, 0, "R7", 32'hB2);
    access(0, 0, 8'h2A, 2'd1, 0, "R7", 32'hA1B2);
    access(0, 0, 8'h28, 2'd2, 0, "R7", 32'hA1B2C3D4);
    access(0, 0, 8'hFE, 2'd1, 0, "R7", 32'hBEEF);

    // R8: slot interrupt summary
    access(0, 0, 8'hFC, 2'd1, 0, "R8", 32'h1);
    access(1, 0, 8'hFC, 2'd1, 0, "R8", 32'h1);
    poke(0, 8'h38, 32'h0000000F);
    access(0, 0, 8'hFC, 2'd1, 0, "R8", 32'h0);

    // R9: fixed power byte, writes discarded
    for (int u = 0; u < 2; u++) begin
      access(u, 0, 8'h29, 2'd0, 0, "R9", 32'h0D);
      c = wrCnt[u];
      access(u, 1, 8'h29, 2'd0, 32'h00, "R9", 0);
      check("R9 no write", wrCnt[u], c);
      check("R9 word kept", mem[u][10], 32'hA1B2C3D4);
    end

    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule